// File: doc/BRIEF.md
# Grouped Interrupt Distributor with Fast-Interrupt Routing

This block chooses, for each of several CPUs, the interrupt to present next. Each interrupt line arrives with pending, enable, priority and CPU-target state from the surrounding distributor logic. The block holds two kinds of programmable state behind a byte-wide register port. The first is a control byte with a group-0 enable, a group-1 enable and a fast-routing enable. The second is one group bit per interrupt. The port also exposes a read-only type byte that describes the interrupt and CPU counts.

For every CPU the block runs a purely combinational arbitration. The best candidate is the pending, enabled interrupt aimed at that CPU with the numerically lowest priority value. It is published as the current pending ID when it beats the CPU's priority mask, and it raises an output when it also beats the CPU's running priority. In revision-2 mode with fast routing on, a winning group-0 interrupt drives the CPU's fast-interrupt output instead of its normal output. A revision parameter reduces the block to revision-1 behaviour, in which only the group-0 enable exists and the group bits are absent.

Top module: `gid_top`

## Requirements
- R1: Control byte at address 0x00 (revision 2): bit 0 is the group-0 enable, bit 1 the group-1 enable and bit 3 the fast-routing enable. All other bits read 0. All three bits reset to 0.
- R2: In revision-1 mode, only bit 0 of the control byte is stored and read back. Group bytes read 0 and ignore writes. The fast outputs stay low.
- R3: Address 0x04 reads (NUM_IRQ/32 - 1) in bits 4:0 and (NUM_CPU - 1) in bits 7:5. Addresses 0x01-0x03 and 0x05-0x07 read 0. Writes to 0x01-0x07 change nothing.
- R4: Group byte at 0x80+k holds interrupt 8k+i in bit i, where 1 means group 1 and 0 means group 0. The byte is readable and writable, and all group bits reset to 0.
- R5: A request with `req_i` high to any address other than 0x00-0x07 or 0x80 to 0x80+NUM_IRQ/8-1 raises `err_o` in the same cycle and alters no state.
- R6: An interrupt competes for CPU c only if pending, enable and target bit c are all 1. The lowest priority value wins, and equal values go to the lowest interrupt ID.
- R7: The current pending ID of a CPU is the winner's ID when the winner's priority is strictly below that CPU's priority mask. Otherwise, including when there is no candidate, it is 1023.
- R8: An output for a CPU is raised only when the winner's priority is also strictly below that CPU's running priority.
- R9: When the group-0 enable or the CPU's enable is 0, that CPU's normal and fast outputs are both low and its ID is 1023.
- R10: In revision 2 with fast routing on, a raised group-0 winner drives the fast output high and holds the normal output low. In every other case the fast output is low.
- R11: Outputs follow the interrupt-state inputs within the same cycle. A register write takes effect on the rising clock edge that ends the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| err_o | output | 1 | Access to an unimplemented address |
| pend_i | input | NUM_IRQ | Pending flag per interrupt |
| en_i | input | NUM_IRQ | Enable flag per interrupt |
| prio_i | input | NUM_IRQ*8 | Priority of interrupt n in bits 8n+7:8n |
| target_i | input | NUM_IRQ*NUM_CPU | Bit n*NUM_CPU+c targets interrupt n at CPU c |
| cpu_en_i | input | NUM_CPU | Enable of each CPU's interface |
| pmask_i | input | NUM_CPU*8 | Priority mask of CPU c in bits 8c+7:8c |
| rprio_i | input | NUM_CPU*8 | Running priority of CPU c in bits 8c+7:8c |
| irq_o | output | NUM_CPU | Normal interrupt output per CPU |
| fiq_o | output | NUM_CPU | Fast interrupt output per CPU |
| cur_id_o | output | NUM_CPU*10 | Current pending ID of CPU c in bits 10c+9:10c |

## Verification
The assertions watch every cycle for the following. Neither output is ever high when the group-0 enable or the CPU enable is off. Normal and fast outputs are never high together. A spurious ID never comes with a raised output. The fast line stays quiet without routing or in revision 1. Errors appear only with a request, and control writes land one edge later. Which interrupt wins depends on the whole state, including tie breaking on equal priorities and the strict comparisons against the mask and the running priority. Only the bench's scenarios can show that, because it compares the outputs against a model of the arbitration. The same holds for the exact byte layouts of the type and group registers.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  typedef struct packed {
    logic fast_en;
    logic grp1_en;
    logic grp0_en;
  } ctrl_t;
endpackage

// File: rtl/gid_regs.sv
module gid_regs
  import gid_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned REV     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               err_o,
  output ctrl_t              ctrl_o,
  output logic [NUM_IRQ-1:0] group_o
);
  localparam logic       IS_REV2   = (REV >= 2);
  localparam int unsigned GRP_BYTES = NUM_IRQ / 8;
  localparam int unsigned IDX_W     = $clog2(GRP_BYTES);
  localparam logic [7:0] GRP_LIM   = 8'(GRP_BYTES);
  localparam logic [7:0] TYPE_VAL  = 8'(((NUM_IRQ / 32) - 1) | ((NUM_CPU - 1) << 5));

  ctrl_t              ctrl_q;
  logic [NUM_IRQ-1:0] group_q;
  logic [7:0]         grp_off;
  logic               in_grp, in_low, wr;
  logic [IDX_W+2:0]   bit_base;

  assign grp_off  = addr_i - 8'h80;
  assign in_grp   = addr_i[7] && (grp_off < GRP_LIM);
  assign in_low   = (addr_i < 8'h08);
  assign err_o    = req_i && !(in_grp || in_low);
  assign wr       = req_i && we_i && (in_grp || in_low);
  assign bit_base = {grp_off[IDX_W-1:0], 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      group_q <= '0;
    end else if (wr) begin
      if (addr_i == 8'h00) begin
        ctrl_q.grp0_en <= wdata_i[0];
        if (IS_REV2) begin
          ctrl_q.grp1_en <= wdata_i[1];
          ctrl_q.fast_en <= wdata_i[3];
        end
      end
      if (in_grp && IS_REV2) group_q[bit_base +: 8] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == 8'h00)
      rdata_o = {4'b0000, ctrl_q.fast_en, 1'b0, ctrl_q.grp1_en, ctrl_q.grp0_en};
    else if (addr_i == 8'h04)
      rdata_o = TYPE_VAL;
    else if (in_grp && IS_REV2)
      rdata_o = group_q[bit_base +: 8];
  end

  assign ctrl_o  = ctrl_q;
  assign group_o = group_q;
endmodule

// File: rtl/gid_cpu_sel.sv
module gid_cpu_sel
  import gid_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ-1:0]        group_i,
  input  logic [PRIO_W-1:0]         pmask_i,
  input  logic [PRIO_W-1:0]         rprio_i,
  input  logic                      active_i,
  input  logic                      fast_route_i,
  output logic [ID_W-1:0]           id_o,
  output logic                      irq_o,
  output logic                      fiq_o
);
  logic [PRIO_W:0]   best_p;
  logic [ID_W-1:0]   best_id;
  logic              best_g;
  logic              shown, level, to_fast;

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    best_p  = {1'b1, {PRIO_W{1'b0}}};
    best_id = NONE_ID;
    best_g  = 1'b0;
    for (int i = 0; i < int'(NUM_IRQ); i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best_p)) begin
        best_p  = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
        best_id = ID_W'(i);
        best_g  = group_i[i];
      end
    end
  end

  assign shown   = active_i && !best_p[PRIO_W] && (best_p[PRIO_W-1:0] < pmask_i);
  assign level   = shown && (best_p[PRIO_W-1:0] < rprio_i);
  assign to_fast = fast_route_i && !best_g;
  assign id_o    = shown ? best_id : NONE_ID;
  assign irq_o   = level && !to_fast;
  assign fiq_o   = level && to_fast;
endmodule

// File: rtl/gid_top.sv
module gid_top
  import gid_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned REV     = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [7:0]                  addr_i,
  input  logic [7:0]                  wdata_i,
  output logic [7:0]                  rdata_o,
  output logic                        err_o,
  input  logic [NUM_IRQ-1:0]          pend_i,
  input  logic [NUM_IRQ-1:0]          en_i,
  input  logic [NUM_IRQ*8-1:0]        prio_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]  target_i,
  input  logic [NUM_CPU-1:0]          cpu_en_i,
  input  logic [NUM_CPU*8-1:0]        pmask_i,
  input  logic [NUM_CPU*8-1:0]        rprio_i,
  output logic [NUM_CPU-1:0]          irq_o,
  output logic [NUM_CPU-1:0]          fiq_o,
  output logic [NUM_CPU*10-1:0]       cur_id_o
);
  localparam logic IS_REV2 = (REV >= 2);

  ctrl_t              ctrl;
  logic [NUM_IRQ-1:0] group;
  logic               grp0_en, fast_en;

  gid_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .REV(REV)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .ctrl_o  (ctrl),
    .group_o (group)
  );

  assign grp0_en = ctrl.grp0_en;
  assign fast_en = ctrl.fast_en && IS_REV2;

  for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    for (genvar i = 0; i < int'(NUM_IRQ); i++) begin : g_cand
      assign cand[i] = pend_i[i] && en_i[i] && target_i[i*NUM_CPU+c];
    end
    gid_cpu_sel #(.NUM_IRQ(NUM_IRQ)) u_sel (
      .cand_i       (cand),
      .prio_i       (prio_i),
      .group_i      (group),
      .pmask_i      (pmask_i[c*8 +: 8]),
      .rprio_i      (rprio_i[c*8 +: 8]),
      .active_i     (grp0_en && cpu_en_i[c]),
      .fast_route_i (fast_en),
      .id_o         (cur_id_o[c*ID_W +: ID_W]),
      .irq_o        (irq_o[c]),
      .fiq_o        (fiq_o[c])
    );
  end
endmodule

// File: rtl/gid_chk.sv
module gid_chk #(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned REV     = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [7:0]            addr_i,
  input logic [7:0]            wdata_i,
  input logic                  err_o,
  input logic [NUM_CPU-1:0]    cpu_en_i,
  input logic [NUM_CPU-1:0]    irq_o,
  input logic [NUM_CPU-1:0]    fiq_o,
  input logic [NUM_CPU*10-1:0] cur_id_o,
  input logic                  grp0_en,
  input logic                  fast_en
);
  // R5
  err_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_i);

  // R1
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h00) |=> (grp0_en == $past(wdata_i[0])));

  for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
    // R9
    gated_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!grp0_en || !cpu_en_i[c]) |->
        (!irq_o[c] && !fiq_o[c] && cur_id_o[c*10 +: 10] == 10'd1023));
    // R10
    one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(irq_o[c] && fiq_o[c]));
    // R10
    fast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fast_en |-> !fiq_o[c]);
    // R7
    spurious_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_id_o[c*10 +: 10] == 10'd1023) |-> (!irq_o[c] && !fiq_o[c]));
    if (REV < 2) begin : g_r1
      // R2
      rev1_no_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fiq_o[c]);
    end
  end
endmodule

bind gid_top gid_chk #(.NUM_CPU(NUM_CPU), .REV(REV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .err_o    (err_o),
  .cpu_en_i (cpu_en_i),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .cur_id_o (cur_id_o),
  .grp0_en  (grp0_en),
  .fast_en  (fast_en)
);

// File: tb/gid_top_test.sv
`timescale 1ns/1ps
module gid_top_test;
  localparam int NI = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req = 0, we = 0;
  logic [7:0]      addr = 0, wdata = 0, rdata;
  logic            err;
  logic [NI-1:0]   pend = '0, en = '0;
  logic [NI*8-1:0] prio = '0;
  logic [NI*NC-1:0] tgt = '0;
  logic [NC-1:0]   cpu_en = '0;
  logic [NC*8-1:0] pmask = '0, rprio = '0;
  logic [NC-1:0]   irq, fiq;
  logic [NC*10-1:0] cur_id;

  gid_top #(.NUM_IRQ(NI), .NUM_CPU(NC), .REV(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .pend_i(pend), .en_i(en),
    .prio_i(prio), .target_i(tgt), .cpu_en_i(cpu_en), .pmask_i(pmask),
    .rprio_i(rprio), .irq_o(irq), .fiq_o(fiq), .cur_id_o(cur_id));

  logic        q_req = 0, q_we = 0;
  logic [7:0]  q_addr = 0, q_wdata = 0, q_rdata;
  logic        q_err;
  logic [0:0]  q_irq, q_fiq;
  logic [9:0]  q_id;

  gid_top #(.NUM_IRQ(32), .NUM_CPU(1), .REV(1)) uut_r1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(q_req), .we_i(q_we), .addr_i(q_addr),
    .wdata_i(q_wdata), .rdata_o(q_rdata), .err_o(q_err), .pend_i(32'h1),
    .en_i(32'h1), .prio_i(256'h0), .target_i(32'hffff_ffff), .cpu_en_i(1'b1),
    .pmask_i(8'hff), .rprio_i(8'hff), .irq_o(q_irq), .fiq_o(q_fiq), .cur_id_o(q_id));

  int n_chk = 0, n_fail = 0;
  logic m_g0 = 0, m_g1 = 0, m_fast = 0;
  logic [NI-1:0] m_grp = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
    if (a == 8'h00) begin m_g0 = d[0]; m_g1 = d[1]; m_fast = d[3]; end
    if (a >= 8'h80 && a < 8'h88) m_grp[(a - 8'h80) * 8 +: 8] = d;
  endtask

  task automatic bus_rd(string tag, logic [7:0] a, logic [7:0] exp, logic exp_err);
    #1; req = 1; we = 0; addr = a;
    #1; chk(tag, 32'(rdata), 32'(exp)); chk(tag, 32'(err), 32'(exp_err));
    req = 0;
  endtask

  task automatic model(int c, output logic [9:0] id, output logic ir, output logic fq);
    int best = 256;
    int bi = -1;
    logic lvl;
    for (int i = 0; i < NI; i++)
      if (pend[i] && en[i] && tgt[i*NC+c] && int'(prio[i*8 +: 8]) < best) begin
        best = int'(prio[i*8 +: 8]); bi = i;
      end
    id = 10'd1023; ir = 0; fq = 0;
    if (!m_g0 || !cpu_en[c] || bi < 0) return;
    if (best >= int'(pmask[c*8 +: 8])) return;
    id = 10'(bi);
    lvl = best < int'(rprio[c*8 +: 8]);
    if (m_fast && !m_grp[bi]) fq = lvl; else ir = lvl;
  endtask

  task automatic check_cpu(string tag, int c);
    logic [9:0] eid; logic ei, ef;
    model(c, eid, ei, ef);
    chk(tag, 32'(cur_id[c*10 +: 10]), 32'(eid));
    chk(tag, 32'(irq[c]), 32'(ei));
    chk(tag, 32'(fiq[c]), 32'(ef));
  endtask

  task automatic set_irq(int i, logic [7:0] p, logic [NC-1:0] t);
    pend[i] = 1; en[i] = 1; prio[i*8 +: 8] = p; tgt[i*NC +: NC] = t;
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // reset state
    bus_rd("R1 reset ctrl", 8'h00, 8'h00, 0);
    bus_rd("R4 reset group", 8'h83, 8'h00, 0);
    check_cpu("R9 reset cpu0", 0);
    chk("R9 reset id1", 32'(cur_id[19:10]), 32'd1023);
    // type and reserved low bytes
    bus_rd("R3 type", 8'h04, 8'h21, 0);
    bus_wr(8'h04, 8'hff); bus_wr(8'h05, 8'hff); bus_wr(8'h02, 8'hff);
    bus_rd("R3 type after write", 8'h04, 8'h21, 0);
    for (int a = 1; a < 8; a++)
      if (a != 4) bus_rd("R3 reserved", 8'(a), 8'h00, 0);
    bus_rd("R3 ctrl untouched", 8'h00, 8'h00, 0);
    // control bits
    bus_wr(8'h00, 8'hff);
    bus_rd("R1 ctrl mask", 8'h00, 8'h0b, 0);
    bus_wr(8'h00, 8'h02);
    bus_rd("R1 ctrl grp1 only", 8'h00, 8'h02, 0);
    // group bytes and bad addresses
    bus_wr(8'h81, 8'ha5); bus_wr(8'h87, 8'h3c);
    bus_rd("R4 group 81", 8'h81, 8'ha5, 0);
    bus_rd("R4 group 87", 8'h87, 8'h3c, 0);
    bus_rd("R4 group 80", 8'h80, 8'h00, 0);
    bus_rd("R5 past end", 8'h88, 8'h00, 1);
    bus_rd("R5 gap", 8'h08, 8'h00, 1);
    bus_rd("R5 below grp", 8'h7f, 8'h00, 1);
    bus_rd("R5 top", 8'hff, 8'h00, 1);
    @(posedge clk); #1; req = 1; we = 1; addr = 8'h88; wdata = 8'hff;
    @(posedge clk); #1; req = 0; we = 0;
    bus_rd("R5 no write past end", 8'h87, 8'h3c, 0);
    bus_wr(8'h81, 8'h00); bus_wr(8'h87, 8'h00);
    // tie break on equal priority
    cpu_en = 2'b11; pmask = 16'hffff; rprio = 16'hffff;
    set_irq(9, 8'h40, 2'b01); set_irq(5, 8'h40, 2'b01);
    bus_wr(8'h00, 8'h01);
    #1 chk("R6 tie lowest id", 32'(cur_id[9:0]), 32'd5);
    chk("R6 untargeted cpu1", 32'(cur_id[19:10]), 32'd1023);
    check_cpu("R6 tie", 0);
    // mask and running priority boundaries (R11: same-cycle response)
    pmask[7:0] = 8'h40; #1;
    chk("R7 mask equal", 32'(cur_id[9:0]), 32'd1023);
    check_cpu("R7 mask equal", 0);
    pmask[7:0] = 8'h41; rprio[7:0] = 8'h40; #1;
    chk("R8 rprio equal id", 32'(cur_id[9:0]), 32'd5);
    chk("R8 rprio equal irq", 32'(irq[0]), 32'd0);
    rprio[7:0] = 8'h41; #1;
    chk("R11 irq comb", 32'(irq[0]), 32'd1);
    // fast routing
    bus_wr(8'h00, 8'h09);
    check_cpu("R10 fast grp0", 0);
    chk("R10 fiq", 32'(fiq[0]), 32'd1);
    bus_wr(8'h80, 8'h20);
    check_cpu("R10 grp1 normal", 0);
    chk("R10 irq grp1", 32'(irq[0]), 32'd1);
    // write timing
    bus_wr(8'h00, 8'h00);
    check_cpu("R9 dist off", 0);
    @(posedge clk); #1; req = 1; we = 1; addr = 8'h00; wdata = 8'h01;
    #1 chk("R11 before edge", 32'(irq[0]), 32'd0);
    @(posedge clk); #1; req = 0; we = 0; m_g0 = 1; m_g1 = 0; m_fast = 0;
    chk("R11 after edge", 32'(irq[0]), 32'd1);
    cpu_en = 2'b10; #1;
    check_cpu("R9 cpu off", 0);
    // random
    for (int it = 0; it < 400; it++) begin
      if (it % 8 == 0) begin
        if ($urandom % 2 == 0) bus_wr(8'h00, 8'($urandom));
        else bus_wr(8'h80 + 8'($urandom % 8), 8'($urandom));
      end
      pend = {$urandom, $urandom}; en = {$urandom, $urandom};
      tgt = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < NI; i++) prio[i*8 +: 8] = 8'(($urandom % 4) * 32);
      cpu_en = 2'($urandom | 32'($urandom % 4 != 0) | (32'($urandom % 4 != 0) << 1));
      pmask = 16'($urandom); rprio = 16'($urandom);
      #1;
      check_cpu("R6 R7 R8 R10 random cpu0", 0);
      check_cpu("R6 R7 R8 R10 random cpu1", 1);
      @(posedge clk);
    end
    // revision 1 instance
    @(posedge clk); #1; q_req = 1; q_we = 1; q_addr = 8'h00; q_wdata = 8'h0b;
    @(posedge clk); #1; q_addr = 8'h80; q_wdata = 8'hff;
    @(posedge clk); #1; q_we = 0; q_addr = 8'h00;
    #1 chk("R2 rev1 ctrl", 32'(q_rdata), 32'h01);
    q_addr = 8'h80;
    #1 chk("R2 rev1 group raz", 32'(q_rdata), 32'h00);
    chk("R2 rev1 group err", 32'(q_err), 32'd0);
    q_addr = 8'h04;
    #1 chk("R3 rev1 type", 32'(q_rdata), 32'h00);
    q_req = 0;
    chk("R2 rev1 irq", 32'(q_irq), 32'd1);
    chk("R2 rev1 no fiq", 32'(q_fiq), 32'd0);
    chk("R2 rev1 id", 32'(q_id), 32'd0);
    finish_run();
  end
endmodule